// File: doc/BRIEF.md
# Endpoint DMA Transfer Handler

This block manages DMA traffic for a single endpoint FIFO. Software arms it with one configuration write. The write carries an enable bit, a 4-bit endpoint index and a byte count. While armed, the handler raises a request toward an external DMA controller whenever the selected FIFO can take part in a transfer. For an IN endpoint that means the FIFO holds data; for an OUT endpoint it means the FIFO has free room. Each acknowledged request moves one byte. The handler decrements its counter and sends a one-cycle byte strobe to the selected FIFO.

A transfer ends on any of three events: the byte count runs out, software writes the enable bit back to zero, or the DMA controller signals end-of-transfer. On any of them the handler does three things. It flushes the selected FIFO with a one-cycle clear strobe, whether or not data is still waiting. It disarms itself. It reports the reason through a one-cycle done pulse and a 2-bit cause code. Nothing further happens until software arms it again.

Endpoint 0 is reserved for programmed I/O, and index 15 is also not available for DMA. An arming write that names either of them, or that gives a zero byte count, is refused and raises an error flag.

Top module: `epdma_handler`

## Requirements
- R1: After reset the handler is idle: busy, cfg_err, dma_req, done and all strobes are 0, done_cause is 00 and count_left is 0.
- R2: While idle, a write with cfg_en=1, an index from 1 to 14 and a nonzero count arms the handler. From the next cycle, busy=1, count_left equals the written count and cfg_err=0.
- R3: While idle, a write with cfg_en=1 and index 0, index 15 or a zero count leaves busy=0 and sets cfg_err=1. cfg_err stays set until a later write arms the handler.
- R4: dma_req is 1 exactly when busy=1 and the selected endpoint is ready. When ep_dir_in of that endpoint is 1, ready means fifo_has_data is set for it; otherwise ready means fifo_has_space is set for it. The flags of other endpoints have no effect.
- R5: A cycle with dma_ack=1 and dma_req=1 decrements count_left by one. In the same cycle it drives byte_strb one-hot at the selected endpoint's bit.
- R6: An accepted acknowledge while count_left is 1 ends the transfer with cause 01.
- R7: While busy, a write with cfg_en=0 ends the transfer with cause 10.
- R8: While busy, dma_eot=1 ends the transfer with cause 11. If end-of-transfer and the last byte arrive in the same cycle, cause 11 is reported.
- R9: In the cycle after the terminating event: done=1 for exactly one cycle with the cause on done_cause; flush_strb is one-hot at the selected endpoint's bit for that same cycle; busy=0 and dma_req=0. done_cause is 00 whenever done=0.
- R10: While idle, dma_ack and dma_eot have no effect. A write with cfg_en=1 while busy is ignored and changes neither the count nor the selected endpoint.
- R11: dma_ack while dma_req=0 is ignored: count_left keeps its value and byte_strb stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable bit of the write |
| cfg_idx | input | 4 | Endpoint index of the write |
| cfg_count | input | 16 | Byte count of the write |
| ep_dir_in | input | 16 | Per-endpoint direction, 1 = IN (FIFO supplies data) |
| fifo_has_data | input | 16 | Per-endpoint FIFO not empty |
| fifo_has_space | input | 16 | Per-endpoint FIFO not full |
| dma_ack | input | 1 | DMA acknowledge, one byte per cycle |
| dma_eot | input | 1 | End-of-transfer from the DMA controller |
| dma_req | output | 1 | DMA request |
| byte_strb | output | 16 | One-hot byte move strobe to the selected FIFO |
| flush_strb | output | 16 | One-hot one-cycle clear strobe to the selected FIFO |
| busy | output | 1 | Handler armed |
| cfg_err | output | 1 | Last arming write was refused |
| done | output | 1 | One-cycle termination pulse |
| done_cause | output | 2 | 01 count, 10 software, 11 end-of-transfer |
| count_left | output | 16 | Remaining byte count |

## Verification
The bench walks each termination path and checks the cause code, the one-cycle width of done, and the endpoint bit that the flush strobe lands on. Three design faults are aimed at directly:
- Arming on index 0 or 15 would show up as busy rising instead of an error.
- Giving the count path priority over end-of-transfer in the shared last-byte cycle would report 01 instead of 11.
- Failing to disarm would let stray acknowledges or end-of-transfer pulses keep counting, or produce a second done.

The bench also checks that a late arming write during a transfer does not reload the count, and that an acknowledge with no pending request is not counted.

// File: rtl/epdma_pkg.sv
package epdma_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'b00,
      CAUSE_COUNT = 2'b01,
      CAUSE_SWOFF = 2'b10,
      CAUSE_EOT   = 2'b11
   } cause_e;

endpackage

// File: rtl/epdma_idx_check.sv
module epdma_idx_check #(
   parameter int IDX_W = 4,
   parameter int LO    = 1,
   parameter int HI    = 14
) (
   input  logic [IDX_W-1:0] idx,
   output logic             ok
);
   localparam int TOP = (1 << IDX_W) - 1;

   generate
      if (LO == 0 && HI == TOP) begin : g_all
         assign ok = 1'b1;
      end else begin : g_range
         assign ok = (int'(idx) >= LO) && (int'(idx) <= HI);
      end
   endgenerate
endmodule

// File: rtl/epdma_counter.sv
module epdma_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] value,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (dec)  cnt_q <= cnt_q - CNT_W'(1);
   end

   assign value = cnt_q;
   assign last  = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/epdma_onehot.sv
module epdma_onehot #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic             en,
   input  logic [IDX_W-1:0] idx,
   output logic [N-1:0]     vec
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign vec[i] = en && (idx == IDX_W'(i));
      end
   endgenerate
endmodule

// File: rtl/epdma_handler.sv
module epdma_handler #(
   parameter int NUM_EP = 16,
   parameter int CNT_W  = 16,
   parameter int IDX_W  = $clog2(NUM_EP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_en,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic [NUM_EP-1:0] ep_dir_in,
   input  logic [NUM_EP-1:0] fifo_has_data,
   input  logic [NUM_EP-1:0] fifo_has_space,
   input  logic              dma_ack,
   input  logic              dma_eot,
   output logic              dma_req,
   output logic [NUM_EP-1:0] byte_strb,
   output logic [NUM_EP-1:0] flush_strb,
   output logic              busy,
   output logic              cfg_err,
   output logic              done,
   output logic [1:0]        done_cause,
   output logic [CNT_W-1:0]  count_left
);
   import epdma_pkg::*;

   localparam int DMA_LO = 1;
   localparam int DMA_HI = NUM_EP - 2;

   generate
      if (NUM_EP < 3) begin : g_bad_ep
         $error("epdma_handler: NUM_EP must be at least 3");
      end
      if ((1 << IDX_W) < NUM_EP) begin : g_bad_idx
         $error("epdma_handler: IDX_W too narrow for NUM_EP");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("epdma_handler: CNT_W must be positive");
      end
   endgenerate

   logic              busy_q, err_q, done_q;
   logic [IDX_W-1:0]  sel_q;
   cause_e            cause_q, cause_n;
   logic [NUM_EP-1:0] flush_q, flush_n;
   logic              idx_ok, cnt_ok, arm_wr, start, reject;
   logic              side_ok, take, cnt_last;
   logic              hit_eot, hit_cnt, hit_off, term;

   epdma_idx_check #(.IDX_W(IDX_W), .LO(DMA_LO), .HI(DMA_HI)) u_idx (
      .idx (cfg_idx),
      .ok  (idx_ok)
   );

   assign cnt_ok = |cfg_count;
   assign arm_wr = cfg_wr && cfg_en;
   assign start  = !busy_q && arm_wr && idx_ok && cnt_ok;
   assign reject = !busy_q && arm_wr && !(idx_ok && cnt_ok);

   assign side_ok = ep_dir_in[sel_q] ? fifo_has_data[sel_q] : fifo_has_space[sel_q];
   assign dma_req = busy_q && side_ok;
   assign take    = dma_req && dma_ack;

   epdma_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .load_val (cfg_count),
      .dec      (take),
      .value    (count_left),
      .last     (cnt_last)
   );

   assign hit_eot = busy_q && dma_eot;
   assign hit_cnt = take && cnt_last;
   assign hit_off = busy_q && cfg_wr && !cfg_en;
   assign term    = hit_eot || hit_cnt || hit_off;

   always_comb begin
      if (hit_eot)      cause_n = CAUSE_EOT;
      else if (hit_cnt) cause_n = CAUSE_COUNT;
      else              cause_n = CAUSE_SWOFF;
   end

   epdma_onehot #(.N(NUM_EP), .IDX_W(IDX_W)) u_byte (
      .en  (take),
      .idx (sel_q),
      .vec (byte_strb)
   );

   epdma_onehot #(.N(NUM_EP), .IDX_W(IDX_W)) u_flush (
      .en  (term),
      .idx (sel_q),
      .vec (flush_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         err_q   <= 1'b0;
         sel_q   <= '0;
         done_q  <= 1'b0;
         cause_q <= CAUSE_NONE;
         flush_q <= '0;
      end else begin
         if (start) begin
            busy_q <= 1'b1;
            sel_q  <= cfg_idx;
         end else if (term) begin
            busy_q <= 1'b0;
         end
         if (start)       err_q <= 1'b0;
         else if (reject) err_q <= 1'b1;
         done_q  <= term;
         cause_q <= term ? cause_n : CAUSE_NONE;
         flush_q <= flush_n;
      end
   end

   assign busy       = busy_q;
   assign cfg_err    = err_q;
   assign done       = done_q;
   assign done_cause = cause_q;
   assign flush_strb = flush_q;
endmodule

// File: rtl/epdma_checker.sv
module epdma_checker #(
   parameter int NUM_EP = 16,
   parameter int CNT_W  = 16,
   parameter int IDX_W  = $clog2(NUM_EP)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic              cfg_en,
   input logic [IDX_W-1:0]  cfg_idx,
   input logic              dma_ack,
   input logic              dma_eot,
   input logic              dma_req,
   input logic [NUM_EP-1:0] flush_strb,
   input logic              busy,
   input logic              cfg_err,
   input logic              done,
   input logic [1:0]        done_cause,
   input logic [CNT_W-1:0]  count_left
);
   a_r4_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> busy);

   a_r3_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cfg_wr && cfg_en &&
       (cfg_idx == '0 || cfg_idx == IDX_W'(NUM_EP - 1))) |=> (cfg_err && !busy));

   a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dma_req && dma_ack) |=> (count_left == $past(count_left) - CNT_W'(1)));

   a_r6_count_end: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dma_req && dma_ack && count_left == CNT_W'(1) && !dma_eot)
      |=> (done && done_cause == 2'b01));

   a_r7_sw_end: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_wr && !cfg_en && !dma_eot &&
       !(dma_req && dma_ack && count_left == CNT_W'(1)))
      |=> (done && done_cause == 2'b10));

   a_r8_eot_end: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dma_eot) |=> (done && done_cause == 2'b11));

   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !dma_req));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_flush_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flush_strb) && ((flush_strb != '0) == done));

   a_r9_cause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (done_cause == 2'b00));

   a_r10_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !done);

   a_r11_no_req_no_count: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !dma_req && !cfg_wr) |=> $stable(count_left));
endmodule

bind epdma_handler epdma_checker #(.NUM_EP(NUM_EP), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .cfg_en     (cfg_en),
   .cfg_idx    (cfg_idx),
   .dma_ack    (dma_ack),
   .dma_eot    (dma_eot),
   .dma_req    (dma_req),
   .flush_strb (flush_strb),
   .busy       (busy),
   .cfg_err    (cfg_err),
   .done       (done),
   .done_cause (done_cause),
   .count_left (count_left)
);

// File: tb/tb_epdma_handler.sv
module tb_epdma_handler;
   localparam int NEP = 16;
   localparam int CW  = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_wr = 1'b0, cfg_en = 1'b0;
   logic [3:0]      cfg_idx = '0;
   logic [CW-1:0]   cfg_count = '0;
   logic [NEP-1:0]  ep_dir_in = '0, fifo_has_data = '0, fifo_has_space = '0;
   logic            dma_ack = 1'b0, dma_eot = 1'b0;
   logic            dma_req, busy, cfg_err, done;
   logic [NEP-1:0]  byte_strb, flush_strb;
   logic [1:0]      done_cause;
   logic [CW-1:0]   count_left;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   epdma_handler dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_idx(cfg_idx),
      .cfg_count(cfg_count), .ep_dir_in(ep_dir_in), .fifo_has_data(fifo_has_data),
      .fifo_has_space(fifo_has_space), .dma_ack(dma_ack), .dma_eot(dma_eot),
      .dma_req(dma_req), .byte_strb(byte_strb), .flush_strb(flush_strb), .busy(busy),
      .cfg_err(cfg_err), .done(done), .done_cause(done_cause), .count_left(count_left)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input logic en, input logic [3:0] idx, input logic [CW-1:0] cnt);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_en = en; cfg_idx = idx; cfg_count = cnt;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_en = 1'b0;
   endtask

   task automatic ack_once(input string req, input int ep);
      @(negedge clk);
      dma_ack = 1'b1;
      #1 chk(req, "byte_strb", 32'(byte_strb), 32'(1 << ep));
      @(negedge clk);
      dma_ack = 1'b0;
   endtask

   task automatic expect_end(input string req, input int ep, input logic [1:0] cause);
      chk(req, "done", 32'(done), 32'd1);
      chk(req, "done_cause", 32'(done_cause), 32'(cause));
      chk(req, "flush_strb", 32'(flush_strb), 32'(1 << ep));
      chk(req, "busy", 32'(busy), 32'd0);
      chk(req, "dma_req", 32'(dma_req), 32'd0);
      @(negedge clk);
      chk("R9", "done width", 32'(done), 32'd0);
      chk("R9", "cause quiet", 32'(done_cause), 32'd0);
      chk("R9", "flush width", 32'(flush_strb), 32'd0);
   endtask

   task automatic t_reset;
      chk("R1", "busy", 32'(busy), 0);
      chk("R1", "cfg_err", 32'(cfg_err), 0);
      chk("R1", "dma_req", 32'(dma_req), 0);
      chk("R1", "done", 32'(done), 0);
      chk("R1", "done_cause", 32'(done_cause), 0);
      chk("R1", "strobes", 32'(byte_strb | flush_strb), 0);
      chk("R1", "count_left", 32'(count_left), 0);
   endtask

   task automatic t_bad_index;
      cfg_write(1'b1, 4'd0, 16'd4);
      chk("R3", "idx0 busy", 32'(busy), 0);
      chk("R3", "idx0 err", 32'(cfg_err), 1);
      cfg_write(1'b1, 4'd15, 16'd4);
      chk("R3", "idx15 busy", 32'(busy), 0);
      chk("R3", "idx15 err", 32'(cfg_err), 1);
      cfg_write(1'b1, 4'd3, 16'd0);
      chk("R3", "zero count busy", 32'(busy), 0);
      chk("R3", "zero count err", 32'(cfg_err), 1);
   endtask

   task automatic t_arm_and_request;
      cfg_write(1'b1, 4'd5, 16'd3);
      chk("R2", "busy", 32'(busy), 1);
      chk("R2", "count_left", 32'(count_left), 3);
      chk("R2", "err cleared", 32'(cfg_err), 0);
      ep_dir_in = 16'h0020; fifo_has_data = 16'hFFDF; fifo_has_space = 16'hFFFF;
      #1 chk("R4", "IN no data, others ready", 32'(dma_req), 0);
      fifo_has_data = 16'h0020; fifo_has_space = 16'h0000;
      #1 chk("R4", "IN with data", 32'(dma_req), 1);
      ep_dir_in = 16'h0000;
      #1 chk("R4", "OUT no space", 32'(dma_req), 0);
      fifo_has_space = 16'h0020;
      #1 chk("R4", "OUT with space", 32'(dma_req), 1);
      cfg_write(1'b0, 4'd0, 16'd0);
      expect_end("R7", 5, 2'b10);
   endtask

   task automatic t_count_end;
      ep_dir_in = '0; fifo_has_space = 16'h0080; fifo_has_data = '0;
      cfg_write(1'b1, 4'd7, 16'd3);
      ack_once("R5", 7);
      chk("R5", "count after 1", 32'(count_left), 2);
      ack_once("R5", 7);
      chk("R5", "count after 2", 32'(count_left), 1);
      chk("R6", "no early done", 32'(done), 0);
      ack_once("R5", 7);
      expect_end("R6", 7, 2'b01);
   endtask

   task automatic t_ack_without_req;
      fifo_has_space = '0; ep_dir_in = '0;
      cfg_write(1'b1, 4'd9, 16'd10);
      @(negedge clk);
      dma_ack = 1'b1;
      #1 chk("R11", "byte_strb", 32'(byte_strb), 0);
      @(negedge clk);
      dma_ack = 1'b0;
      chk("R11", "count held", 32'(count_left), 10);
      fifo_has_space = 16'h0200;
      ack_once("R5", 9);
      cfg_write(1'b1, 4'd2, 16'd50);
      chk("R10", "rearm while busy keeps count", 32'(count_left), 9);
      chk("R10", "still busy", 32'(busy), 1);
      fifo_has_space = 16'h0004;
      #1 chk("R10", "selection kept", 32'(dma_req), 0);
      cfg_write(1'b0, 4'd0, 16'd0);
      expect_end("R7", 9, 2'b10);
   endtask

   task automatic t_eot;
      ep_dir_in = 16'h0004; fifo_has_data = 16'h0004;
      cfg_write(1'b1, 4'd2, 16'd10);
      @(negedge clk);
      dma_eot = 1'b1;
      @(negedge clk);
      dma_eot = 1'b0;
      expect_end("R8", 2, 2'b11);
      ep_dir_in = 16'h0010; fifo_has_data = 16'h0010;
      cfg_write(1'b1, 4'd4, 16'd1);
      @(negedge clk);
      dma_ack = 1'b1; dma_eot = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0; dma_eot = 1'b0;
      expect_end("R8", 4, 2'b11);
   endtask

   task automatic t_idle_ignored;
      fifo_has_data = '1; fifo_has_space = '1;
      @(negedge clk);
      dma_ack = 1'b1; dma_eot = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0; dma_eot = 1'b0;
      chk("R10", "idle busy", 32'(busy), 0);
      chk("R10", "idle done", 32'(done), 0);
      chk("R10", "idle count", 32'(count_left), 0);
      chk("R10", "idle flush", 32'(flush_strb), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_bad_index;
      t_arm_and_request;
      t_count_end;
      t_ack_without_req;
      t_eot;
      t_idle_ignored;
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule